// File: doc/BRIEF.md
# Shared Lock and Mailbox Memory

This block is a small word-addressed memory that several processors share. They use it both to take locks and to pass short messages to one another. Each processor has its own request port. A fixed-priority arbiter admits one access per cycle, so a lock acquisition is an indivisible read-and-mark step. No other access can slip between the test and the set.

The low part of the array holds lock words. Reading a lock word that holds zero returns zero and leaves the word holding one. The caller then owns the lock, and it releases the lock by writing zero. The upper part of the array is cut into equal mailbox regions, one per processor. When a processor writes into another processor's region, the block raises that owner's interrupt line. Each processor clears its own pending interrupt by writing to a single acknowledge address, and it can read that address to see its pending flag. This removes the need to poll the mailboxes.

Top module: `semmem_top`

## Requirements
- R1: After reset every interrupt line is low, no read response is valid, and every storage word holds zero.
- R2: A read of a lock word (address below LOCKS) that holds zero returns zero, and the word holds one afterwards.
- R3: A read of a word that holds a nonzero value returns that value and leaves the word unchanged.
- R4: A write stores its data in the addressed word as an ordinary memory does, and writing zero to a lock word releases it. Any processor may access any word.
- R5: When several processors request in the same cycle, the lowest-numbered one is served first, and exactly one access is performed per cycle. Of two simultaneous reads of a free lock, the lower-numbered processor receives zero and the other receives one.
- R6: A read of a mailbox word (address LOCKS to LOCKS+N*MBW-1) returns its content without modifying it, and it raises no interrupt.
- R7: A write by processor q into the region of processor p (addresses LOCKS+p*MBW to LOCKS+p*MBW+MBW-1), with q different from p, sets p's interrupt line from the cycle after the access, and affects no other line.
- R8: A processor's write into its own mailbox region does not raise its own interrupt.
- R9: A write by processor p to the acknowledge address (LOCKS+N*MBW+... that is, address DEPTH = LOCKS+N*MBW) clears p's pending interrupt only.
- R10: A read of the acknowledge address returns the reader's pending flag in bit 0, with zeros above it.
- R11: An access to an address above DEPTH is ignored: a read returns zero and a write changes no word and no interrupt.
- R12: The read response appears on the granted port's rdata slice, with its rvalid bit high, in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-processor access request, held until granted |
| we | input | N | Per-processor write enable (1 = write) |
| addr | input | N*AW | Per-processor word address, processor p in bits p*AW upward |
| wdata | input | N*DW | Per-processor write data |
| gnt | output | N | Combinational grant, at most one bit set |
| rvalid | output | N | Read response valid, one cycle after grant |
| rdata | output | N*DW | Per-processor read response data |
| irq | output | N | Per-processor pending message interrupt |

## Verification
The bench aims at three races and boundaries: two processors reading the same free lock in one cycle, a lock read as the first access after a release, and writes that land at the edges of mailbox regions. A design that broke up the test-and-set, or got the priority wrong, would hand the lock to both callers or to the wrong caller. A design that marked mailbox words on read would corrupt message data that later readers see. Further checks target self-writes, an acknowledge from a non-owner and out-of-range addresses. A design that decoded the region owner or the acknowledge source wrongly would raise or clear the wrong interrupt line.

// File: rtl/semmem_pkg.sv
package semmem_pkg;

  // true when word address a lies in [base, base+len)
  function automatic bit in_window(int a, int base, int len);
    return (a >= base) && (a < base + len);
  endfunction

  // processor that owns mailbox word a
  function automatic int mbox_owner(int a, int locks, int mbw);
    return (a - locks) / mbw;
  endfunction

endpackage

// File: rtl/semmem_arbiter.sv
module semmem_arbiter #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic [IDW-1:0] win_id,
  output logic           win_any
);

  always_comb begin
    gnt     = '0;
    win_id  = '0;
    win_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !win_any) begin
        gnt[i]  = 1'b1;
        win_id  = IDW'(i);
        win_any = 1'b1;
      end
    end
  end

  // R5: single access per cycle, only to requesters, lowest index first
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r5_grant_requested: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n) req[0] |-> gnt[0]);

endmodule

// File: rtl/semmem_store.sv
module semmem_store #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int DEPTH = 32,
  parameter int LOCKS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] word_now,
  output logic          in_range
);
  import semmem_pkg::*;

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic          is_lock;
  logic          tas_hit;

  assign in_range = in_window(int'(acc_addr), 0, DEPTH);
  assign idx      = acc_addr[IW-1:0];
  assign is_lock  = in_window(int'(acc_addr), 0, LOCKS);
  assign word_now = in_range ? mem[idx] : '0;
  assign tas_hit  = acc && !acc_we && in_range && is_lock && (mem[idx] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (acc && in_range) begin
      if (acc_we)       mem[idx] <= acc_wdata;
      else if (tas_hit) mem[idx] <= DW'(1);
    end
  end

  // R2: a free lock read leaves the word marked
  a_r2_tas_marks: assert property (@(posedge clk) disable iff (!rst_n)
    tas_hit |=> mem[$past(idx)] == DW'(1));
  // R3: reading a nonzero word does not alter it
  a_r3_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_we && in_range && mem[idx] != '0) |=> mem[$past(idx)] == $past(mem[idx]));
  // R6: reading a mailbox word does not alter it
  a_r6_mbox_read_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_we && in_range && !is_lock) |=> mem[$past(idx)] == $past(mem[idx]));

endmodule

// File: rtl/semmem_notify.sv
module semmem_notify #(
  parameter int N        = 4,
  parameter int AW       = 6,
  parameter int IDW      = 2,
  parameter int LOCKS    = 16,
  parameter int MBW      = 4,
  parameter int ACK_ADDR = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           acc_we,
  input  logic [AW-1:0]  acc_addr,
  input  logic [IDW-1:0] acc_src,
  output logic [N-1:0]   pend
);
  import semmem_pkg::*;

  logic          in_mbox;
  int            owner;
  logic [N-1:0]  set_ev;
  logic [N-1:0]  clr_ev;

  assign in_mbox = in_window(int'(acc_addr), LOCKS, N * MBW);
  assign owner   = mbox_owner(int'(acc_addr), LOCKS, MBW);

  for (genvar p = 0; p < N; p++) begin : g_line
    assign set_ev[p] = acc && acc_we && in_mbox && (owner == p) && (int'(acc_src) != p);
    assign clr_ev[p] = acc && acc_we && (int'(acc_addr) == ACK_ADDR) && (int'(acc_src) == p);

    always_ff @(posedge clk) begin
      if (!rst_n)         pend[p] <= 1'b0;
      else if (set_ev[p]) pend[p] <= 1'b1;
      else if (clr_ev[p]) pend[p] <= 1'b0;
    end

    // R7: a line only rises after a write from some other processor
    a_r7_rise_needs_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[p]) |-> $past(acc && acc_we && int'(acc_src) != p));
    // R8: a processor's own access never raises its own line
    a_r8_self_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && int'(acc_src) == p && !pend[p]) |=> !pend[p]);
    // R9: acknowledge by the owner clears the line
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && acc_we && int'(acc_addr) == ACK_ADDR && int'(acc_src) == p) |=> !pend[p]);
  end

endmodule

// File: rtl/semmem_top.sv
module semmem_top #(
  parameter int N     = 4,
  parameter int DW    = 32,
  parameter int LOCKS = 16,
  parameter int MBW   = 4,
  parameter int DEPTH = LOCKS + N * MBW,
  parameter int AW    = $clog2(DEPTH + 1) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic [N-1:0]    gnt,
  output logic [N-1:0]    rvalid,
  output logic [N*DW-1:0] rdata,
  output logic [N-1:0]    irq
);

  localparam int IDW      = (N > 1) ? $clog2(N) : 1;
  localparam int ACK_ADDR = DEPTH;

  logic [IDW-1:0] win_id;
  logic           acc;
  logic           sel_we;
  logic [AW-1:0]  sel_addr;
  logic [DW-1:0]  sel_wdata;
  logic [DW-1:0]  word_now;
  logic           in_range;
  logic [DW-1:0]  read_val;
  logic [N-1:0]   pend;

  semmem_arbiter #(.N(N), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
    .win_id(win_id), .win_any(acc));

  always_comb begin
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        sel_we    = we[i];
        sel_addr  = addr[i*AW +: AW];
        sel_wdata = wdata[i*DW +: DW];
      end
    end
  end

  semmem_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .LOCKS(LOCKS)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_we(sel_we), .acc_addr(sel_addr),
    .acc_wdata(sel_wdata), .word_now(word_now), .in_range(in_range));

  semmem_notify #(.N(N), .AW(AW), .IDW(IDW), .LOCKS(LOCKS), .MBW(MBW),
                  .ACK_ADDR(ACK_ADDR)) u_notify (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_we(sel_we), .acc_addr(sel_addr),
    .acc_src(win_id), .pend(pend));

  always_comb begin
    if (int'(sel_addr) == ACK_ADDR) read_val = DW'(pend[win_id]);
    else if (in_range)              read_val = word_now;
    else                            read_val = '0;
  end

  for (genvar p = 0; p < N; p++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rvalid[p]            <= 1'b0;
        rdata[p*DW +: DW]    <= '0;
      end else begin
        rvalid[p]            <= gnt[p];
        rdata[p*DW +: DW]    <= gnt[p] ? read_val : '0;
      end
    end
  end

  assign irq = pend;

  // R12: a response only follows a grant to that port
  a_r12_resp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rvalid) && ((rvalid & ~$past(gnt)) == '0));
  // R11: out-of-range accesses never change the interrupt lines
  a_r11_oob_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_range && int'(sel_addr) != ACK_ADDR) |=> irq == $past(irq));

endmodule

// File: tb/test_semmem_top.sv
`timescale 1ns/1ps
module test_semmem_top;
  localparam int N = 4, DW = 32, LOCKS = 16, MBW = 4;
  localparam int DEPTH = LOCKS + N * MBW;
  localparam int AW = $clog2(DEPTH + 1) + 1;
  localparam int ACK = DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0] gnt, rvalid, irq;
  logic [N*DW-1:0] rdata;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  semmem_top #(.N(N), .DW(DW), .LOCKS(LOCKS), .MBW(MBW)) i_semmem_top (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .gnt(gnt), .rvalid(rvalid), .rdata(rdata), .irq(irq));

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access from processor p; returns read data
  task automatic access(int p, bit w, int a, logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = AW'(a);
    wdata[p*DW +: DW] = d;
    #1;
    while (!gnt[p]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
    rd = rdata[p*DW +: DW];
    if (!rvalid[p]) begin
      n_chk++; n_bad++;
      $display("FAIL R12: actual rvalid 0 expected 1");
    end
  endtask

  task automatic t_reset();
    check("R1 irq after reset", DW'(irq), 0);
    check("R1 rvalid after reset", DW'(rvalid), 0);
  endtask

  task automatic t_tas();
    logic [DW-1:0] r;
    access(1, 0, 3, 0, r); check("R2 free lock read", r, 0);
    access(2, 0, 3, 0, r); check("R3 taken lock read", r, 1);
    access(1, 0, 3, 0, r); check("R3 taken lock stays", r, 1);
  endtask

  task automatic t_write();
    logic [DW-1:0] r;
    access(0, 1, 3, 0, r);
    access(3, 0, 3, 0, r); check("R4 release then reacquire", r, 0);
    access(3, 1, 5, 32'hA5, r);
    access(0, 0, 5, 0, r); check("R4 stored data", r, 32'hA5);
    access(1, 0, 5, 0, r); check("R3 nonzero unchanged", r, 32'hA5);
  endtask

  task automatic t_prio();
    logic [DW-1:0] r0, r2;
    fork
      access(0, 0, 7, 0, r0);
      access(2, 0, 7, 0, r2);
    join
    check("R5 high priority wins lock", r0, 0);
    check("R5 low priority sees taken", r2, 1);
  endtask

  task automatic t_mbox();
    logic [DW-1:0] r;
    access(0, 0, LOCKS + 2*MBW, 0, r); check("R6 mailbox read", r, 0);
    access(0, 0, LOCKS + 2*MBW, 0, r); check("R6 mailbox not marked", r, 0);
    check("R6 read raises no irq", DW'(irq), 0);
  endtask

  task automatic t_notify();
    logic [DW-1:0] r;
    access(1, 1, LOCKS + 2*MBW, 32'h11, r);
    check("R7 owner irq only", DW'(irq), 32'h4);
    access(3, 1, LOCKS + MBW - 1, 32'h22, r);
    check("R7 region edge raises p0", DW'(irq), 32'h5);
    access(2, 0, LOCKS + 2*MBW, 0, r); check("R6 message content", r, 32'h11);
  endtask

  task automatic t_own();
    logic [DW-1:0] r;
    access(3, 1, LOCKS + 3*MBW, 32'h33, r);
    check("R8 own region no irq", DW'(irq), 32'h5);
  endtask

  task automatic t_ack();
    logic [DW-1:0] r;
    access(2, 0, ACK, 0, r); check("R10 pending flag read", r, 1);
    access(1, 1, ACK, 0, r); check("R9 non-owner ack no effect", DW'(irq), 32'h5);
    access(2, 1, ACK, 0, r); check("R9 owner ack clears", DW'(irq), 32'h1);
    access(0, 1, ACK, 0, r); check("R9 p0 ack clears", DW'(irq), 0);
    access(2, 0, ACK, 0, r); check("R10 cleared flag read", r, 0);
  endtask

  task automatic t_oob();
    logic [DW-1:0] r;
    access(1, 1, DEPTH + 8, 32'h77, r);
    check("R11 oob write no irq", DW'(irq), 0);
    access(1, 0, DEPTH + 8, 0, r); check("R11 oob read zero", r, 0);
    access(1, 0, 0, 0, r); check("R11 word 0 untouched", r, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tas();
    t_write();
    t_prio();
    t_mbox();
    t_notify();
    t_own();
    t_ack();
    t_oob();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule